// File: doc/BRIEF.md
# CAN Bus Error Capture and Interrupt

This block sits between the bit stream processor of a CAN protocol engine and the CPU register interface. The protocol engine reports every detected bus error as a one-cycle event that carries the error type, the direction (transmit or receive) and the frame segment the engine was in. The first report is latched into an 8-bit capture word, and the bus error interrupt flag is raised if the interrupt enable is set.

After a capture, the block holds the capture word and drops its acceptance of new reports. It keeps this state until the CPU reads the capture word once. A read of the interrupt register returns the flag and clears it in the same access. Because error reports are not accepted while the capture is held, a second bus error interrupt cannot be raised until software has read the captured code.

The error input uses valid/ready naming, but it carries no back-pressure. The protocol engine never stalls and never repeats a report. A report presented while `err_ready` is low is dropped for good. `err_ready` is high exactly when the capture is free.

Top module: `can_buserr_capture`

## Requirements
- R1: An error report accepted (`err_valid` and `err_ready` both high) while `irq_en` is high sets the interrupt flag. `irq` and `ir_rdata` are high from the next cycle on.
- R2: An accepted report is stored as `cap_rdata` = {type[1:0], dir, seg[4:0]}. Type codes are 0 bit, 1 form, 2 stuff and 3 other; dir 1 means receive. The stored word is visible from the cycle after acceptance.
- R3: Once a report is accepted, `cap_rdata` holds its value and `err_ready` stays low until a capture read (`cap_rd`) takes place.
- R4: A `cap_rd` while the capture is held makes `err_ready` high in the next cycle. The next report after that is captured and overwrites the word.
- R5: While `ir_rd` is high, `ir_rdata` shows the flag value as it stood before the read. The flag is cleared at the end of that cycle.
- R6: An accepted report with `irq_en` high in the same cycle as `ir_rd` leaves the flag set after the read, because the clear takes effect first.
- R7: A report presented while the capture is held changes neither `cap_rdata` nor the flag.
- R8: A report accepted while `irq_en` is low is still captured and holds the capture, but it leaves the flag unchanged.
- R9: A synchronous reset (`rst` high at a clock edge) clears `cap_rdata` to 0, clears the flag and sets `err_ready` high.
- R10: A report that arrives in the same cycle as a `cap_rd` of a held capture is dropped. The capture becomes free only after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| err_valid | input | 1 | Bus error event from the bit stream processor |
| err_ready | output | 1 | High when the capture is free to accept a report |
| err_type | input | 2 | Error type code |
| err_dir | input | 1 | Direction, 1 = receive |
| err_seg | input | 5 | Frame segment code |
| irq_en | input | 1 | Bus error interrupt enable |
| cap_rd | input | 1 | CPU read strobe for the capture word |
| cap_rdata | output | 8 | Capture word |
| ir_rd | input | 1 | CPU read strobe for the interrupt register |
| ir_rdata | output | 1 | Bus error flag as read (value before the clear) |
| irq | output | 1 | Interrupt output, equal to the flag |

## Verification
The hardest situations to reach are the collisions: an error report that lands in the same cycle as a capture read, and an error report that lands in the same cycle as an interrupt register read. Either one decides whether a report is dropped or an interrupt is lost. The stimulus covers both with directed sequences. It then runs a long random phase that drives error reports, reads and enable changes at high density, so that these collisions recur many times while the capture is held and while it is free. A cycle-accurate reference model checks every cycle of the random phase.

// File: rtl/can_bec_pkg.sv
package can_bec_pkg;
  localparam int TYPE_W = 2;
  localparam int SEG_W  = 5;
  localparam int CAP_W  = TYPE_W + 1 + SEG_W;

  typedef enum logic [TYPE_W-1:0] {
    ERR_BIT   = 2'd0,
    ERR_FORM  = 2'd1,
    ERR_STUFF = 2'd2,
    ERR_OTHER = 2'd3
  } err_kind_e;

  typedef struct packed {
    err_kind_e        kind;
    logic             rx;
    logic [SEG_W-1:0] seg;
  } cap_word_t;
endpackage

// File: rtl/can_bec_capture.sv
module can_bec_capture
  import can_bec_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      ev_valid,
  input  cap_word_t ev_word,
  input  logic      rd,
  output logic      accept,
  output logic      held,
  output cap_word_t word
);
  cap_word_t word_q;
  logic      held_q;

  assign accept = ev_valid && !held_q;
  assign held   = held_q;
  assign word   = word_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      word_q <= '0;
      held_q <= 1'b0;
    end else if (accept) begin
      word_q <= ev_word;
      held_q <= 1'b1;
    end else if (rd) begin
      held_q <= 1'b0;
    end
  end

  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    held_q && !rd |=> $stable(word_q) && held_q);
  p_store_r2: assert property (@(posedge clk) disable iff (rst)
    accept |=> held_q && word_q == $past(ev_word));
  p_rearm_r4: assert property (@(posedge clk) disable iff (rst)
    held_q && rd |=> !held_q);
  p_drop_r10: assert property (@(posedge clk) disable iff (rst)
    held_q && ev_valid |=> $stable(word_q));
endmodule

// File: rtl/can_bec_flag.sv
module can_bec_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_ev,
  input  logic en,
  input  logic rd,
  output logic flag
);
  logic flag_q;
  assign flag = flag_q;

  always_ff @(posedge clk) begin
    if (rst) flag_q <= 1'b0;
    else     flag_q <= (flag_q && !rd) || (set_ev && en);
  end

  p_set_r1: assert property (@(posedge clk) disable iff (rst)
    set_ev && en |=> flag_q);
  p_clear_r5: assert property (@(posedge clk) disable iff (rst)
    rd && !(set_ev && en) |=> !flag_q);
  p_rise_r7: assert property (@(posedge clk) disable iff (rst)
    !flag_q && !(set_ev && en) |=> !flag_q);
endmodule

// File: rtl/can_buserr_capture.sv
module can_buserr_capture
  import can_bec_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             err_valid,
  output logic             err_ready,
  input  logic [TYPE_W-1:0] err_type,
  input  logic             err_dir,
  input  logic [SEG_W-1:0] err_seg,
  input  logic             irq_en,
  input  logic             cap_rd,
  output logic [CAP_W-1:0] cap_rdata,
  input  logic             ir_rd,
  output logic             ir_rdata,
  output logic             irq
);
  cap_word_t ev_word;
  cap_word_t word;
  logic      accept;
  logic      held;
  logic      flag;

  assign ev_word = '{kind: err_kind_e'(err_type), rx: err_dir, seg: err_seg};

  can_bec_capture u_cap (
    .clk(clk), .rst(rst), .ev_valid(err_valid), .ev_word(ev_word),
    .rd(cap_rd), .accept(accept), .held(held), .word(word)
  );

  can_bec_flag u_flag (
    .clk(clk), .rst(rst), .set_ev(accept), .en(irq_en),
    .rd(ir_rd), .flag(flag)
  );

  assign err_ready = !held;
  assign cap_rdata = word;
  assign ir_rdata  = flag;
  assign irq       = flag;

  p_locked_no_irq_r7: assert property (@(posedge clk) disable iff (rst)
    !err_ready && !irq |=> !irq);
  p_reset_r9: assert property (@(posedge clk)
    rst |=> err_ready && !irq && cap_rdata == '0);
endmodule

// File: tb/test_can_buserr_capture.sv
module test_can_buserr_capture;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 100000;

  logic clk = 0, rst = 1;
  logic err_valid = 0, err_dir = 0, irq_en = 0, cap_rd = 0, ir_rd = 0;
  logic [1:0] err_type = 0;
  logic [4:0] err_seg = 0;
  logic err_ready, ir_rdata, irq;
  logic [7:0] cap_rdata;

  int checks = 0, errors = 0;
  int m_held = 0, m_flag = 0, m_cap = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  can_buserr_capture i_can_buserr_capture (
    .clk(clk), .rst(rst), .err_valid(err_valid), .err_ready(err_ready),
    .err_type(err_type), .err_dir(err_dir), .err_seg(err_seg),
    .irq_en(irq_en), .cap_rd(cap_rd), .cap_rdata(cap_rdata),
    .ir_rd(ir_rd), .ir_rdata(ir_rdata), .irq(irq)
  );

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic compare(string tag);
    chk(tag, "err_ready", int'(err_ready), m_held ? 0 : 1);
    chk(tag, "cap_rdata", int'(cap_rdata), m_cap);
    chk(tag, "irq", int'(irq), m_flag);
    chk(tag, "ir_rdata", int'(ir_rdata), m_flag);
  endtask

  // Drive one cycle of inputs, advance the model at the edge, compare after it.
  task automatic step(string tag, bit v, int ty, bit dir, int seg, bit en, bit crd, bit ird);
    bit acc;
    err_valid = v; err_type = 2'(ty); err_dir = dir; err_seg = 5'(seg);
    irq_en = en; cap_rd = crd; ir_rd = ird;
    #1;
    if (ird) chk(tag, "ir_rdata before clear", int'(ir_rdata), m_flag);
    @(posedge clk);
    acc = v && (m_held == 0);
    m_flag = ((m_flag != 0) && !ird) || (acc && en) ? 1 : 0;
    if (acc) begin
      m_cap = ty * 64 + dir * 32 + seg;
      m_held = 1;
    end else if (crd) m_held = 0;
    @(negedge clk);
    err_valid = 0; cap_rd = 0; ir_rd = 0;
    compare(tag);
  endtask

  task automatic do_reset();
    rst = 1;
    @(posedge clk);
    m_held = 0; m_flag = 0; m_cap = 0;
    @(negedge clk);
    rst = 0;
    compare("R9");
  endtask

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R1 R2: stuff error, receive, segment 0x13
    step("R1", 1, 2, 1, 19, 1, 0, 0);
    chk("R2", "word", int'(cap_rdata), 2*64 + 32 + 19);
    // R7: locked, new error ignored
    step("R7", 1, 1, 0, 4, 1, 0, 0);
    // R5: interrupt read returns 1, then clears
    step("R5", 0, 0, 0, 0, 1, 0, 1);
    chk("R5", "irq cleared", int'(irq), 0);
    // R7: still locked, error does not raise flag
    step("R7", 1, 3, 1, 7, 1, 0, 0);
    chk("R7", "no irq while held", int'(irq), 0);
    // R10: error in same cycle as capture read is dropped
    step("R10", 1, 1, 1, 9, 1, 1, 0);
    chk("R10", "word kept", int'(cap_rdata), 2*64 + 32 + 19);
    // R4: now free, next error overwrites
    step("R4", 1, 0, 0, 31, 1, 0, 0);
    chk("R4", "overwrite", int'(cap_rdata), 31);
    // R6: error with ir read same cycle keeps flag set
    step("R3", 0, 0, 0, 0, 1, 1, 0);
    step("R6", 1, 3, 1, 1, 1, 0, 1);
    chk("R6", "flag after collision", int'(irq), 1);
    step("R5", 0, 0, 0, 0, 1, 1, 1);
    // R8: enable low, captured, no flag
    step("R8", 1, 1, 0, 12, 0, 0, 0);
    chk("R8", "no flag", int'(irq), 0);
    chk("R8", "held", int'(err_ready), 0);
    // R9: reset mid-run
    step("R1", 0, 0, 0, 0, 1, 1, 0);
    step("R1", 1, 2, 0, 3, 1, 0, 0);
    do_reset();
    // Random phase against the model
    for (int i = 0; i < 4000; i++) begin
      step("R3", ($urandom % 3) != 0, $urandom % 4, $urandom % 2, $urandom % 32,
           ($urandom % 4) != 0, ($urandom % 5) == 0, ($urandom % 4) == 0);
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule